// File: doc/BRIEF.md
# Byte-Stepped I2C Master Engine

This block is an I2C bus master that software steers one byte at a time through four small registers: a data byte, a command register, a status register and a bit-rate divider. Software places the target address with its direction bit in the data register and then asks for a start condition. The engine sends the start condition and the address without further help. After each byte it stops and raises a pending flag next to a three-bit state code, and then waits for the next command.

In read transfers the engine holds back the acknowledge bit of each received byte. A continue command answers with ACK and fetches the next byte. A stop command answers with NAK and then closes the bus. A start command answers with NAK and then issues a repeated start. In write transfers each continue command sends the byte held in the data register. While the engine waits for software it keeps SCL low, so the bus is stretched for as long as software takes. Both bus lines are open-drain: the block only asserts pull-low enables and reads back the wired line levels.

Top module: `i2cm_engine`

## Requirements
- R1: After reset the status register reads 0x01 (pending set, state idle) and neither bus line is pulled low.
- R2: Register select 0 is the data byte, 1 is the command register (reads as 0), 2 is status and 3 is the divider. Status bit 0 is the pending flag and bits 3:1 are the state code: 0 idle, 1 byte received, 2 ready to transmit, 3 address refused, 4 data refused. Bits 7:4 read 0 and no other state code ever appears.
- R3: In idle, a command with bit 1 (start) set sends a start condition and then the data register as the address byte. If the slave ACKs an address whose bit 0 is 0, the engine reports state 2 with pending. If the address is NAKed, it reports state 3.
- R4: If the slave ACKs an address whose bit 0 is 1, the engine receives a byte at once and reports state 1 with pending. The received byte then reads back from the data register.
- R5: In state 1, a command with only bit 0 (continue) set ACKs the held byte and receives the next one, then reports state 1 again.
- R6: In state 1, a command with bit 2 (stop) set NAKs the held byte and sends a stop condition, then reports idle with pending.
- R7: In state 2, a continue command sends the data register. An ACK gives state 2 and a NAK gives state 4, both with pending.
- R8: In states 1 to 4, a command with start set (and stop clear) produces a repeated start followed by the data register as the new address.
- R9: In states 2, 3 and 4, a command with stop set sends a stop condition and reports idle with pending. Stop takes priority over start, and start takes priority over continue.
- R10: A command that is valid for the current state clears pending one cycle after the write. A command that has no meaning in the current state is ignored: continue in idle, stop in idle, and continue in state 3 or 4. Pending then stays set and the bus lines do not move.
- R11: While pending is set in any state other than idle, SCL is pulled low and neither line changes.
- R12: Within a byte, consecutive SCL rising edges are 4*(divider+1) clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_sel |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
Register reads are combinational, so status and data can be checked in the same cycle they are selected. A valid command must show pending cleared at the first sample after its write edge, and the bench checks it exactly there. The end of a byte depends on the divider and on the slave's answer, so the bench polls status for pending and then checks the state code and data together with a bench slave model's log. For bit timing, the bench takes SCL rising-edge times inside a transmitted byte and requires them to be exactly 4*(divider+1) cycles apart.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;
    localparam logic [1:0] SEL_DIV  = 2'd3;

    localparam int CMD_CONT  = 0;
    localparam int CMD_START = 1;
    localparam int CMD_STOP  = 2;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        MS_IDLE   = 3'd0,
        MS_RXRDY  = 3'd1,
        MS_TXRDY  = 3'd2,
        MS_ADRNAK = 3'd3,
        MS_DATNAK = 3'd4
    } mstate_t;

    typedef enum logic [2:0] {
        BC_START,
        BC_STOP,
        BC_SEND,
        BC_RECV,
        BC_ACKB
    } bcmd_t;

    typedef enum logic [2:0] {
        SQ_WAIT,
        SQ_START,
        SQ_ADDR,
        SQ_DATA,
        SQ_RECV,
        SQ_ACKB,
        SQ_STOP
    } seq_t;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } drv_t;

    typedef struct packed {
        logic go;
        seq_t first;
        seq_t after;
        logic nak;
    } plan_t;

    // Line levels for one quarter of a bit slot.
    function automatic drv_t drive_for(bcmd_t c, logic [1:0] ph, logic bv);
        drv_t d;
        case (c)
            BC_START: begin
                d.scl_low = (ph == 2'd0) || (ph == 2'd3);
                d.sda_low = (ph >= 2'd2);
            end
            BC_STOP: begin
                d.scl_low = (ph == 2'd0);
                d.sda_low = (ph <= 2'd1);
            end
            default: begin
                d.scl_low = (ph == 2'd0) || (ph == 2'd3);
                d.sda_low = !bv;
            end
        endcase
        return d;
    endfunction

    function automatic logic [3:0] slots_for(bcmd_t c);
        case (c)
            BC_SEND: return 4'(BYTE_BITS + 1);
            BC_RECV: return 4'(BYTE_BITS);
            default: return 4'd1;
        endcase
    endfunction

    function automatic bcmd_t bcmd_of(seq_t s);
        case (s)
            SQ_START: return BC_START;
            SQ_RECV:  return BC_RECV;
            SQ_ACKB:  return BC_ACKB;
            SQ_STOP:  return BC_STOP;
            default:  return BC_SEND;
        endcase
    endfunction

    // Decode a command write in the given state; stop > start > continue.
    function automatic plan_t plan_cmd(mstate_t c, logic [2:0] w);
        plan_t p;
        p.go    = 1'b0;
        p.first = SQ_WAIT;
        p.after = SQ_WAIT;
        p.nak   = 1'b1;
        case (c)
            MS_IDLE: begin
                if (w[CMD_START]) begin
                    p.go = 1'b1; p.first = SQ_START;
                end
            end
            MS_RXRDY: begin
                if (w[CMD_STOP]) begin
                    p.go = 1'b1; p.first = SQ_ACKB; p.after = SQ_STOP;
                end else if (w[CMD_START]) begin
                    p.go = 1'b1; p.first = SQ_ACKB; p.after = SQ_START;
                end else if (w[CMD_CONT]) begin
                    p.go = 1'b1; p.first = SQ_ACKB; p.after = SQ_RECV; p.nak = 1'b0;
                end
            end
            MS_TXRDY: begin
                if (w[CMD_STOP]) begin
                    p.go = 1'b1; p.first = SQ_STOP;
                end else if (w[CMD_START]) begin
                    p.go = 1'b1; p.first = SQ_START;
                end else if (w[CMD_CONT]) begin
                    p.go = 1'b1; p.first = SQ_DATA;
                end
            end
            default: begin
                if (w[CMD_STOP]) begin
                    p.go = 1'b1; p.first = SQ_STOP;
                end else if (w[CMD_START]) begin
                    p.go = 1'b1; p.first = SQ_START;
                end
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/i2cm_bitlane.sv
module i2cm_bitlane
    import i2cm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        cmd_valid,
    input  bcmd_t       cmd,
    input  logic [7:0]  tx_byte,
    input  logic        ack_val,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rx_byte,
    output logic        ack_seen,
    output logic        scl_low,
    output logic        sda_low
);
    bcmd_t      cmd_q,  cmd_d;
    logic [1:0] ph_q,   ph_d;
    logic [3:0] slot_q, slot_d;
    logic [7:0] sh_q,   sh_d;
    logic       ackb_q, ackb_d;
    logic       busy_q, busy_d;
    logic       seen_q, seen_d;
    drv_t       drv_q,  drv_d;
    logic       adv;
    logic       last_slot;
    logic       bv;

    assign last_slot = (slot_q == slots_for(cmd_q) - 4'd1);
    // Hold the high quarter while the line is still low (slave stretching).
    assign adv = busy_q && tick && !((ph_q == 2'd1) && !scl_in);

    always_comb begin
        cmd_d  = cmd_q;
        ph_d   = ph_q;
        slot_d = slot_q;
        sh_d   = sh_q;
        ackb_d = ackb_q;
        busy_d = busy_q;
        seen_d = seen_q;
        done   = 1'b0;
        if (!busy_q) begin
            if (cmd_valid) begin
                cmd_d  = cmd;
                ph_d   = 2'd0;
                slot_d = 4'd0;
                sh_d   = tx_byte;
                ackb_d = ack_val;
                busy_d = 1'b1;
            end
        end else if (adv) begin
            case (ph_q)
                2'd2: begin
                    ph_d = 2'd3;
                    if (cmd_q == BC_RECV) begin
                        sh_d = {sh_q[6:0], sda_in};
                    end
                    if ((cmd_q == BC_SEND) && (slot_q == 4'(BYTE_BITS))) begin
                        seen_d = sda_in;
                    end
                end
                2'd3: begin
                    if (last_slot) begin
                        busy_d = 1'b0;
                        done   = 1'b1;
                    end else begin
                        slot_d = slot_q + 4'd1;
                        ph_d   = 2'd0;
                        if (cmd_q == BC_SEND) begin
                            sh_d = {sh_q[6:0], 1'b0};
                        end
                    end
                end
                default: ph_d = ph_q + 2'd1;
            endcase
        end
    end

    always_comb begin
        case (cmd_d)
            BC_SEND: bv = (slot_d < 4'(BYTE_BITS)) ? sh_d[7] : 1'b1;
            BC_ACKB: bv = ackb_d;
            default: bv = 1'b1;
        endcase
        drv_d = busy_d ? drive_for(cmd_d, ph_d, bv) : drv_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= BC_STOP;
            ph_q   <= 2'd0;
            slot_q <= 4'd0;
            sh_q   <= 8'd0;
            ackb_q <= 1'b1;
            busy_q <= 1'b0;
            seen_q <= 1'b1;
            drv_q  <= '{scl_low: 1'b0, sda_low: 1'b0};
        end else begin
            cmd_q  <= cmd_d;
            ph_q   <= ph_d;
            slot_q <= slot_d;
            sh_q   <= sh_d;
            ackb_q <= ackb_d;
            busy_q <= busy_d;
            seen_q <= seen_d;
            drv_q  <= drv_d;
        end
    end

    assign busy     = busy_q;
    assign rx_byte  = sh_q;
    assign ack_seen = seen_q;
    assign scl_low  = drv_q.scl_low;
    assign sda_low  = drv_q.sda_low;
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [DIV_W-1:0] div,
    output logic             pending,
    output logic [2:0]       mcode,
    output logic             cmd_valid,
    output bcmd_t            cmd,
    output logic [7:0]       tx_byte,
    output logic             ack_val,
    input  logic             bit_busy,
    input  logic             bit_done,
    input  logic [7:0]       rx_byte,
    input  logic             ack_seen
);
    logic [7:0]       data_q;
    logic [DIV_W-1:0] div_q;
    logic             pend_q;
    mstate_t          code_q;
    seq_t             sq_q;
    seq_t             after_q;
    logic             nak_q;
    logic             launched_q;
    plan_t            plan;

    assign plan = plan_cmd(code_q, reg_wdata[2:0]);

    assign cmd_valid = (sq_q != SQ_WAIT) && !launched_q && !bit_busy;
    assign cmd       = bcmd_of(sq_q);
    assign tx_byte   = data_q;
    assign ack_val   = nak_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= 8'd0;
            div_q      <= DIV_W'(DIV_RST);
            pend_q     <= 1'b1;
            code_q     <= MS_IDLE;
            sq_q       <= SQ_WAIT;
            after_q    <= SQ_WAIT;
            nak_q      <= 1'b1;
            launched_q <= 1'b0;
        end else begin
            if (reg_wr) begin
                case (reg_sel)
                    SEL_DATA: data_q <= reg_wdata;
                    SEL_DIV:  div_q  <= reg_wdata[DIV_W-1:0];
                    SEL_CMD: begin
                        if (pend_q && (sq_q == SQ_WAIT) && plan.go) begin
                            pend_q     <= 1'b0;
                            sq_q       <= plan.first;
                            after_q    <= plan.after;
                            nak_q      <= plan.nak;
                            launched_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (cmd_valid) begin
                launched_q <= 1'b1;
            end
            if (bit_done && launched_q) begin
                launched_q <= 1'b0;
                case (sq_q)
                    SQ_START: sq_q <= SQ_ADDR;
                    SQ_ADDR: begin
                        if (ack_seen) begin
                            sq_q <= SQ_WAIT; code_q <= MS_ADRNAK; pend_q <= 1'b1;
                        end else if (data_q[0]) begin
                            sq_q <= SQ_RECV;
                        end else begin
                            sq_q <= SQ_WAIT; code_q <= MS_TXRDY; pend_q <= 1'b1;
                        end
                    end
                    SQ_DATA: begin
                        sq_q   <= SQ_WAIT;
                        code_q <= ack_seen ? MS_DATNAK : MS_TXRDY;
                        pend_q <= 1'b1;
                    end
                    SQ_RECV: begin
                        data_q <= rx_byte;
                        sq_q   <= SQ_WAIT;
                        code_q <= MS_RXRDY;
                        pend_q <= 1'b1;
                    end
                    SQ_ACKB: sq_q <= after_q;
                    SQ_STOP: begin
                        sq_q <= SQ_WAIT; code_q <= MS_IDLE; pend_q <= 1'b1;
                    end
                    default: sq_q <= SQ_WAIT;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_sel)
            SEL_DATA: reg_rdata = data_q;
            SEL_STAT: reg_rdata = {4'd0, code_q, pend_q};
            SEL_DIV:  reg_rdata = 8'(div_q);
            default:  reg_rdata = 8'd0;
        endcase
    end

    assign div     = div_q;
    assign pending = pend_q;
    assign mcode   = code_q;
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);
    logic [DIV_W-1:0] div_w;
    logic             st_pending;
    logic [2:0]       st_code;
    logic             b_valid, b_busy, b_done, b_ack_val, b_ack_seen, q_tick;
    bcmd_t            b_cmd;
    logic [7:0]       b_tx, b_rx;

    i2cm_seq #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_seq (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .div(div_w), .pending(st_pending), .mcode(st_code),
        .cmd_valid(b_valid), .cmd(b_cmd), .tx_byte(b_tx), .ack_val(b_ack_val),
        .bit_busy(b_busy), .bit_done(b_done), .rx_byte(b_rx), .ack_seen(b_ack_seen)
    );

    i2cm_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .run(b_busy), .div(div_w), .tick(q_tick)
    );

    i2cm_bitlane u_lane (
        .clk(clk), .rst(rst), .tick(q_tick),
        .cmd_valid(b_valid), .cmd(b_cmd), .tx_byte(b_tx), .ack_val(b_ack_val),
        .scl_in(scl_in), .sda_in(sda_in),
        .busy(b_busy), .done(b_done), .rx_byte(b_rx), .ack_seen(b_ack_seen),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );
endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic [7:0] reg_wdata,
    input logic       scl_low,
    input logic       sda_low,
    input logic       pending,
    input logic [2:0] mcode
);
    // R2: only the five defined state codes occur
    a_r2_code_legal: assert property (@(posedge clk) disable iff (rst)
        mcode <= 3'd4);

    // R1: idle with pending leaves the bus released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        (pending && mcode == 3'd0) |-> (!scl_low && !sda_low));

    // R11: bus stretched while software owns a transfer
    a_r11_scl_held: assert property (@(posedge clk) disable iff (rst)
        (pending && mcode != 3'd0) |-> scl_low);

    // R11: no line moves while pending stays set
    a_r11_lines_frozen: assert property (@(posedge clk) disable iff (rst)
        (pending && $past(pending)) |-> ($stable(scl_low) && $stable(sda_low)));

    // R10: a start command is valid in every state and clears pending next cycle
    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd1 && reg_wdata[1] && pending) |=> !pending);
endmodule

bind i2cm_engine i2cm_engine_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .pending(st_pending), .mcode(st_code)
);

// File: tb/i2cm_engine_tb.sv
module i2cm_engine_tb;
    localparam logic [6:0] SLV = 7'h52;
    localparam logic [7:0] NAK_TOKEN = 8'hEE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic scl_drive_low, sda_drive_low;
    logic s_low = 1'b0;
    logic bus_scl, bus_sda;

    assign bus_scl = !scl_drive_low;
    assign bus_sda = !(sda_drive_low || s_low);

    always #4 clk = !clk;

    i2cm_engine u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .scl_in(bus_scl), .sda_in(bus_sda),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    function automatic logic [7:0] rbyte(int i);
        return 8'hA5 ^ 8'(i * 29);
    endfunction

    // ---------------- bench slave model ----------------
    int mode = 0;   // 0 idle, 1 address, 2 write, 3 read
    int bc = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] txb = 8'd0;
    logic ackdec = 1'b0;
    int rd_idx = 0;
    int nak_seen = 0;
    logic [7:0] wlog [0:255];
    int wn = 0;
    realtime rise_prev = 0, rise_last = 0;

    always @(negedge bus_sda) if (bus_scl === 1'b1) begin mode = 1; bc = 0; s_low = 1'b0; end
    always @(posedge bus_sda) if (bus_scl === 1'b1) begin mode = 0; s_low = 1'b0; end

    always @(posedge bus_scl) begin
        rise_prev = rise_last;
        rise_last = $realtime;
        if (mode == 1 || mode == 2) begin
            if (bc < 8) begin
                sh = {sh[6:0], bus_sda};
                if (bc == 7) begin
                    if (mode == 1) ackdec = (sh[7:1] == SLV);
                    else begin
                        ackdec = (sh != NAK_TOKEN);
                        wlog[wn[7:0]] = sh;
                        wn++;
                    end
                end
            end else if (mode == 1) begin
                mode = ackdec ? (sh[0] ? 3 : 2) : 0;
            end
        end else if (mode == 3) begin
            if (bc == 8 && bus_sda) begin mode = 0; nak_seen++; end
        end
        bc = (bc >= 8) ? 0 : bc + 1;
    end

    always @(negedge bus_scl) begin
        if (mode == 1 || mode == 2) s_low = (bc == 8) && ackdec;
        else if (mode == 3) begin
            if (bc == 0) begin txb = rbyte(rd_idx); rd_idx++; end
            s_low = (bc < 8) ? !txb[7 - bc] : 1'b0;
        end else s_low = 1'b0;
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] v);
        @(negedge clk);
        reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic wait_pend();
        logic [7:0] st;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, st);
            if (st[0]) return;
            @(negedge clk);
        end
        check("R10 pending never returned", 0, 1);
    endtask

    task automatic cmd_and_wait(logic [7:0] c, string tag);
        logic [7:0] st;
        wr(2'd1, c);
        rd(2'd2, st);
        check({tag, " R10 pending clears one cycle after command"}, int'(st[0]), 0);
        wait_pend();
    endtask

    task automatic expect_stat(string tag, int exp);
        logic [7:0] st;
        rd(2'd2, st);
        check(tag, int'(st), exp);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] v;
        int exp_rd;
        int wbase;
        logic [7:0] exp_w [0:7];
        void'($urandom(32'd4242));
        exp_rd = 0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        expect_stat("R1 reset status", 8'h01);
        check("R1 scl released", int'(scl_drive_low), 0);
        check("R1 sda released", int'(sda_drive_low), 0);

        // R2 register map
        wr(2'd0, 8'h5A); rd(2'd0, v); check("R2 data readback", int'(v), 8'h5A);
        rd(2'd1, v); check("R2 command reads zero", int'(v), 0);
        wr(2'd3, 8'd1); rd(2'd3, v); check("R2 divider readback", int'(v), 1);

        // R10 ignored commands in idle
        wr(2'd1, 8'h01); expect_stat("R10 continue in idle ignored", 8'h01);
        wr(2'd1, 8'h04); expect_stat("R10 stop in idle ignored", 8'h01);
        check("R10 idle bus untouched", int'(scl_drive_low), 0);

        // R3 write address ACKed
        wbase = wn;
        wr(2'd0, {SLV, 1'b0});
        cmd_and_wait(8'h02, "R3");
        expect_stat("R3 address ACK gives state 2", 8'h05);

        // R7 data ACK, R12 bit period
        wr(2'd0, 8'h3C);
        cmd_and_wait(8'h01, "R7");
        expect_stat("R7 data ACK gives state 2", 8'h05);
        check("R12 SCL period divider 1", int'((rise_last - rise_prev) / 8.0), 8);

        // R11 bus stretched while pending
        repeat (20) @(negedge clk);
        check("R11 SCL held low while pending", int'(scl_drive_low), 1);
        expect_stat("R11 status unchanged while waiting", 8'h05);

        // R7 data NAK
        wr(2'd0, NAK_TOKEN);
        cmd_and_wait(8'h01, "R7");
        expect_stat("R7 data NAK gives state 4", 8'h09);
        check("R7 slave logged 0x3C", int'(wlog[wbase[7:0]]), 8'h3C);

        // R9 stop from state 4 with all bits set: stop wins
        cmd_and_wait(8'h07, "R9");
        expect_stat("R9 stop priority returns idle", 8'h01);
        check("R9 SDA released after stop", int'(sda_drive_low), 0);

        // R3 address NAK
        wr(2'd0, {7'h11, 1'b0});
        cmd_and_wait(8'h02, "R3");
        expect_stat("R3 address NAK gives state 3", 8'h07);
        wr(2'd1, 8'h01);
        expect_stat("R10 continue in state 3 ignored", 8'h07);
        check("R10 SCL still held after ignored command", int'(scl_drive_low), 1);

        // R8 repeated start from state 3 to a read address, R4
        wr(2'd3, 8'd2);
        wr(2'd0, {SLV, 1'b1});
        cmd_and_wait(8'h02, "R8");
        expect_stat("R4 read address gives state 1", 8'h03);
        rd(2'd0, v); check("R4 first read byte", int'(v), int'(rbyte(exp_rd))); exp_rd++;

        // R5 continue reads next byte
        cmd_and_wait(8'h01, "R5");
        expect_stat("R5 state stays 1", 8'h03);
        rd(2'd0, v); check("R5 next read byte", int'(v), int'(rbyte(exp_rd))); exp_rd++;
        check("R12 SCL period divider 2", int'((rise_last - rise_prev) / 8.0), 12);

        // R8 repeated start from state 1 into a write
        wr(2'd0, {SLV, 1'b0});
        cmd_and_wait(8'h03, "R8");
        expect_stat("R8 restart from read reaches state 2", 8'h05);
        check("R8 master NAKed last read byte", nak_seen, 1);

        // R8 restart from state 2 to read then R6 stop
        wr(2'd0, {SLV, 1'b1});
        cmd_and_wait(8'h03, "R8");
        expect_stat("R8 restart from write reaches state 1", 8'h03);
        rd(2'd0, v); check("R8 byte after restart", int'(v), int'(rbyte(exp_rd))); exp_rd++;
        cmd_and_wait(8'h05, "R6");
        expect_stat("R6 stop from read returns idle", 8'h01);
        check("R6 last byte NAKed", nak_seen, 2);

        // Random transactions
        for (int t = 0; t < 16; t++) begin
            int n;
            logic rw;
            logic [7:0] d;
            wr(2'd3, 8'($urandom % 4));
            rw = 1'($urandom % 2);
            n = 1 + int'($urandom % 3);
            wbase = wn;
            wr(2'd0, {SLV, rw});
            cmd_and_wait(8'h02, rw ? "R4" : "R3");
            if (rw) begin
                expect_stat("R4 random read state 1", 8'h03);
                rd(2'd0, v); check("R4 random first byte", int'(v), int'(rbyte(exp_rd))); exp_rd++;
                for (int k = 1; k < n; k++) begin
                    cmd_and_wait(8'h01, "R5");
                    rd(2'd0, v); check("R5 random byte", int'(v), int'(rbyte(exp_rd))); exp_rd++;
                end
                cmd_and_wait(8'h05, "R6");
            end else begin
                expect_stat("R3 random write state 2", 8'h05);
                for (int k = 0; k < n; k++) begin
                    d = 8'($urandom);
                    if (d == NAK_TOKEN) d = 8'h11;
                    exp_w[k] = d;
                    wr(2'd0, d);
                    cmd_and_wait(8'h01, "R7");
                    expect_stat("R7 random write ACK", 8'h05);
                end
                cmd_and_wait(8'h04, "R9");
                for (int k = 0; k < n; k++)
                    check("R7 random byte seen by slave", int'(wlog[8'(wbase + k)]), int'(exp_w[k]));
            end
            expect_stat("R9 random end idle", 8'h01);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule